// File: doc/BRIEF.md
# Sector Write-Erase Protection Checker

This block decides whether a program or erase may touch a given flash sector. A query carries a bank index, a one-hot region code and a sector number. One registered cycle later the block answers with a single protect flag. The sequencer turns that flag into a protect-violation failure of the command.

Protection is held in five registers. The per-sector low register covers main sectors 0 to 31 of bank 0 only. The group register spends one bit on each aligned group of eight main sectors. For bank 0 its low bits are therefore shadowed by the low register, and for every other bank they start at sector 0. The non-main, trim and engineering regions each have a per-sector register.

Software writes the registers over a simple write port. Those writes are refused while a command is running. During a bank erase the same registers serve as a mask that fills up: the sequencer marks each sector once it verifies erased, and the block reports completion once every main sector of the erased bank is marked. When the command ends, every protect bit returns to one.

Top module: `wep_guard`

## Requirements
- R1: After reset the low register and all three per-sector region registers are all ones, and the group register's 28 bits are all ones, so every sector reads protected. `busy`, `hit_valid` and `erase_done` are 0.
- R2: For bank 0 in the main region (region code 1), sectors 0 to 31 are protected exactly when low-register bit `sector` is 1.
- R3: For bank 0, main sectors 32 and above use group-register bit `sector/8`, and group bits 3:0 have no effect on bank 0.
- R4: For any bank other than 0, the low register has no effect, and main sector `s` uses group-register bit `s/8` starting from sector 0.
- R5: Region codes are 2 for non-main, 4 for trim and 8 for engineering, each indexed per sector. Any sector with no covering bit is reported protected: a region sector at or above its register width, or a main sector of 224 or above.
- R6: A region code that is not exactly one of 1, 2, 4 or 8 is reported protected.
- R7: A query presented with `q_valid` in cycle t gives `hit_valid`=1 and `hit` in cycle t+1, judged on the register contents of cycle t.
- R8: A write with `wr_sel` 0 loads the low register, 1 the group register, 2 non-main, 3 trim and 4 engineering, each from the low bits of `wr_data`, and is visible to queries from the next cycle. Other `wr_sel` values change nothing.
- R9: A `cmd_start` pulse sets `busy`. Writes are ignored from the `cmd_start` cycle up to and including the `cmd_done` cycle.
- R10: A `cmd_done` pulse clears `busy` and sets every protect bit of every register to one, taking priority over a write or mark in the same cycle.
- R11: A `mark_valid` pulse sets the protect bit that covers (`mark_bank`, `mark_region`, `mark_sector`), using the mapping of R2 to R5, whether or not a command is running. It never clears a bit.
- R12: `erase_done` is registered. It is 1 one cycle after the bank latched at `cmd_start` has every covering bit of its first `MAIN_SECTORS` main sectors set while `busy` is 1. It is 0 whenever `busy` was 0 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 low, 1 group, 2 non-main, 3 trim, 4 engineering |
| wr_data | input | 32 | Write data |
| cmd_start | input | 1 | Command begins; latches `cmd_bank` and engages the write lock |
| cmd_bank | input | 1 | Bank the command operates on |
| cmd_done | input | 1 | Command ends; restores all protect bits and releases the lock |
| mark_valid | input | 1 | Set the protect bit covering the marked sector |
| mark_bank | input | 1 | Bank of the marked sector |
| mark_region | input | 4 | One-hot region of the marked sector |
| mark_sector | input | 8 | Sector number of the marked sector |
| q_valid | input | 1 | Protection query strobe |
| q_bank | input | 1 | Queried bank |
| q_region | input | 4 | Queried one-hot region |
| q_sector | input | 8 | Queried sector number |
| hit_valid | output | 1 | Query answer valid |
| hit | output | 1 | 1 when the queried sector is protected |
| busy | output | 1 | Command in progress, writes locked |
| erase_done | output | 1 | Every main sector of the latched bank is masked |

## Verification
A wrong bit in any protect register shows up on the next query that lands on that bit. That query gets its answer one cycle later, so the bench sweeps each index rule (low bits, shadowed group bits, group bits of other banks, region bits and uncovered sectors) with pairs of neighbouring sectors whose answers differ. A lock that leaks, or a restore that misses a register, changes a later query answer. A wrong erase mask changes `erase_done`, which the bench samples one cycle after the last mark and again one mark before it.

// File: rtl/wep_pkg.sv
package wep_pkg;
  localparam logic [3:0] RG_MAIN    = 4'h1;
  localparam logic [3:0] RG_NONMAIN = 4'h2;
  localparam logic [3:0] RG_TRIM    = 4'h4;
  localparam logic [3:0] RG_ENGR    = 4'h8;

  typedef enum logic [2:0] {
    SEL_LOW     = 3'd0,
    SEL_GROUP   = 3'd1,
    SEL_NONMAIN = 3'd2,
    SEL_TRIM    = 3'd3,
    SEL_ENGR    = 3'd4
  } wsel_e;
endpackage

// File: rtl/wep_decode.sv
// Maps (bank, region, sector) onto the one protect bit that covers it.
module wep_decode
  import wep_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1,
  parameter int SECT_W    = 8,
  parameter int LO_W      = 32,
  parameter int GRP_W     = 28,
  parameter int GRP_SH    = 3,
  parameter int NM_W      = 4,
  parameter int TR_W      = 4,
  parameter int EN_W      = 4
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [3:0]        region,
  input  logic [SECT_W-1:0] sector,
  output logic [LO_W-1:0]   lo_sel,
  output logic [GRP_W-1:0]  grp_sel,
  output logic [NM_W-1:0]   nm_sel,
  output logic [TR_W-1:0]   tr_sel,
  output logic [EN_W-1:0]   en_sel,
  output logic              covered
);
  logic bank_ok, is_b0, in_low;
  logic r_main, r_nm, r_tr, r_en;

  always_comb begin
    bank_ok = int'(bank) < NUM_BANKS;
    is_b0   = (bank == '0);
    in_low  = is_b0 && (int'(sector) < LO_W);
    r_main  = bank_ok && (region == RG_MAIN);
    r_nm    = bank_ok && (region == RG_NONMAIN);
    r_tr    = bank_ok && (region == RG_TRIM);
    r_en    = bank_ok && (region == RG_ENGR);
    for (int i = 0; i < LO_W; i++)
      lo_sel[i] = r_main && in_low && (int'(sector) == i);
    for (int i = 0; i < GRP_W; i++)
      grp_sel[i] = r_main && !in_low && ((int'(sector) >> GRP_SH) == i);
    for (int i = 0; i < NM_W; i++)
      nm_sel[i] = r_nm && (int'(sector) == i);
    for (int i = 0; i < TR_W; i++)
      tr_sel[i] = r_tr && (int'(sector) == i);
    for (int i = 0; i < EN_W; i++)
      en_sel[i] = r_en && (int'(sector) == i);
    covered = |{lo_sel, grp_sel, nm_sel, tr_sel, en_sel};
  end
endmodule

// File: rtl/wep_regs.sv
// Protect registers, write lock, erase marking and end-of-command restore.
module wep_regs
  import wep_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LO_W   = 32,
  parameter int GRP_W  = 28,
  parameter int NM_W   = 4,
  parameter int TR_W   = 4,
  parameter int EN_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_start,
  input  logic              cmd_done,
  input  logic              mark_valid,
  input  logic [LO_W-1:0]   mk_lo,
  input  logic [GRP_W-1:0]  mk_grp,
  input  logic [NM_W-1:0]   mk_nm,
  input  logic [TR_W-1:0]   mk_tr,
  input  logic [EN_W-1:0]   mk_en,
  output logic [LO_W-1:0]   lo_q,
  output logic [GRP_W-1:0]  grp_q,
  output logic [NM_W-1:0]   nm_q,
  output logic [TR_W-1:0]   tr_q,
  output logic [EN_W-1:0]   en_q,
  output logic              busy_q
);
  logic             wr_ok;
  logic [LO_W-1:0]  lo_d;
  logic [GRP_W-1:0] grp_d;
  logic [NM_W-1:0]  nm_d;
  logic [TR_W-1:0]  tr_d;
  logic [EN_W-1:0]  en_d;

  always_comb begin
    wr_ok = wr_en && !busy_q && !cmd_start;
    lo_d  = lo_q;
    grp_d = grp_q;
    nm_d  = nm_q;
    tr_d  = tr_q;
    en_d  = en_q;
    if (wr_ok) begin
      case (wr_sel)
        SEL_LOW:     lo_d  = wr_data[LO_W-1:0];
        SEL_GROUP:   grp_d = wr_data[GRP_W-1:0];
        SEL_NONMAIN: nm_d  = wr_data[NM_W-1:0];
        SEL_TRIM:    tr_d  = wr_data[TR_W-1:0];
        SEL_ENGR:    en_d  = wr_data[EN_W-1:0];
        default: ;
      endcase
    end
    if (mark_valid) begin
      lo_d  = lo_d  | mk_lo;
      grp_d = grp_d | mk_grp;
      nm_d  = nm_d  | mk_nm;
      tr_d  = tr_d  | mk_tr;
      en_d  = en_d  | mk_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cmd_done) begin
      lo_q  <= '1;
      grp_q <= '1;
      nm_q  <= '1;
      tr_q  <= '1;
      en_q  <= '1;
    end else begin
      lo_q  <= lo_d;
      grp_q <= grp_d;
      nm_q  <= nm_d;
      tr_q  <= tr_d;
      en_q  <= en_d;
    end
    if (rst || cmd_done) busy_q <= 1'b0;
    else if (cmd_start)  busy_q <= 1'b1;
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !cmd_done && !mark_valid) |=> ($stable(lo_q) && $stable(grp_q) && $stable(nm_q) && $stable(tr_q) && $stable(en_q))); // R9
  AST_BUSY_SET: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !cmd_done) |=> busy_q); // R9
  AST_RESTORE_ONES: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> (!busy_q && (&lo_q) && (&grp_q) && (&nm_q) && (&tr_q) && (&en_q))); // R10
  AST_MARK_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (((lo_q & $past(lo_q)) == $past(lo_q)) && ((grp_q & $past(grp_q)) == $past(grp_q)))); // R11
endmodule

// File: rtl/wep_lookup.sv
// Registered protect answer for one query.
module wep_lookup #(
  parameter int LO_W  = 32,
  parameter int GRP_W = 28,
  parameter int NM_W  = 4,
  parameter int TR_W  = 4,
  parameter int EN_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_valid,
  input  logic [LO_W-1:0]  lo_sel,
  input  logic [GRP_W-1:0] grp_sel,
  input  logic [NM_W-1:0]  nm_sel,
  input  logic [TR_W-1:0]  tr_sel,
  input  logic [EN_W-1:0]  en_sel,
  input  logic             covered,
  input  logic [LO_W-1:0]  lo_q,
  input  logic [GRP_W-1:0] grp_q,
  input  logic [NM_W-1:0]  nm_q,
  input  logic [TR_W-1:0]  tr_q,
  input  logic [EN_W-1:0]  en_q,
  output logic             hit_valid,
  output logic             hit
);
  logic prot_c;

  always_comb
    prot_c = !covered || (|(lo_sel & lo_q)) || (|(grp_sel & grp_q)) ||
             (|(nm_sel & nm_q)) || (|(tr_sel & tr_q)) || (|(en_sel & en_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid <= 1'b0;
      hit       <= 1'b0;
    end else begin
      hit_valid <= q_valid;
      hit       <= q_valid && prot_c;
    end
  end

  AST_UNCOVERED_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !covered) |=> hit); // R5
endmodule

// File: rtl/wep_erase_mon.sv
// Tracks whether every main sector of the erased bank has been masked.
module wep_erase_mon #(
  parameter int BANK_W       = 1,
  parameter int MAIN_SECTORS = 64,
  parameter int LO_W         = 32,
  parameter int GRP_W        = 28,
  parameter int GRP_SH       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              busy,
  input  logic [LO_W-1:0]   lo_q,
  input  logic [GRP_W-1:0]  grp_q,
  output logic              erase_done
);
  logic [BANK_W-1:0] bank_q;
  logic [LO_W-1:0]   need_lo;
  logic [GRP_W-1:0]  need_grp;
  logic              b0, all_set;

  always_comb begin
    b0 = (bank_q == '0);
    for (int i = 0; i < LO_W; i++)
      need_lo[i] = b0 && (i < MAIN_SECTORS);
    for (int i = 0; i < GRP_W; i++)
      need_grp[i] = ((i << GRP_SH) < MAIN_SECTORS) && !(b0 && ((i << GRP_SH) < LO_W));
    all_set = (&(lo_q | ~need_lo)) && (&(grp_q | ~need_grp));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q     <= '0;
      erase_done <= 1'b0;
    end else begin
      if (cmd_start && !busy) bank_q <= cmd_bank;
      erase_done <= busy && all_set;
    end
  end

  AST_DONE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !erase_done); // R12
endmodule

// File: rtl/wep_guard.sv
module wep_guard #(
  parameter int NUM_BANKS    = 2,
  parameter int SECT_W       = 8,
  parameter int MAIN_SECTORS = 64,
  parameter int DATA_W       = 32,
  parameter int LO_W         = 32,
  parameter int GRP_W        = 28,
  parameter int GRP_SH       = 3,
  parameter int NM_W         = 4,
  parameter int TR_W         = 4,
  parameter int EN_W         = 4,
  localparam int BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_start,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_done,
  input  logic              mark_valid,
  input  logic [BANK_W-1:0] mark_bank,
  input  logic [3:0]        mark_region,
  input  logic [SECT_W-1:0] mark_sector,
  input  logic              q_valid,
  input  logic [BANK_W-1:0] q_bank,
  input  logic [3:0]        q_region,
  input  logic [SECT_W-1:0] q_sector,
  output logic              hit_valid,
  output logic              hit,
  output logic              busy,
  output logic              erase_done
);
  logic [LO_W-1:0]  lo_q, q_lo, m_lo;
  logic [GRP_W-1:0] grp_q, q_grp, m_grp;
  logic [NM_W-1:0]  nm_q, q_nm, m_nm;
  logic [TR_W-1:0]  tr_q, q_tr, m_tr;
  logic [EN_W-1:0]  en_q, q_en, m_en;
  logic             q_cov, m_cov;

  wep_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .SECT_W(SECT_W), .LO_W(LO_W),
               .GRP_W(GRP_W), .GRP_SH(GRP_SH), .NM_W(NM_W), .TR_W(TR_W), .EN_W(EN_W))
  u_qdec (.bank(q_bank), .region(q_region), .sector(q_sector), .lo_sel(q_lo), .grp_sel(q_grp),
          .nm_sel(q_nm), .tr_sel(q_tr), .en_sel(q_en), .covered(q_cov));

  wep_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .SECT_W(SECT_W), .LO_W(LO_W),
               .GRP_W(GRP_W), .GRP_SH(GRP_SH), .NM_W(NM_W), .TR_W(TR_W), .EN_W(EN_W))
  u_mdec (.bank(mark_bank), .region(mark_region), .sector(mark_sector), .lo_sel(m_lo), .grp_sel(m_grp),
          .nm_sel(m_nm), .tr_sel(m_tr), .en_sel(m_en), .covered(m_cov));

  wep_regs #(.DATA_W(DATA_W), .LO_W(LO_W), .GRP_W(GRP_W), .NM_W(NM_W), .TR_W(TR_W), .EN_W(EN_W))
  u_regs (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
          .cmd_start(cmd_start), .cmd_done(cmd_done), .mark_valid(mark_valid && m_cov),
          .mk_lo(m_lo), .mk_grp(m_grp), .mk_nm(m_nm), .mk_tr(m_tr), .mk_en(m_en),
          .lo_q(lo_q), .grp_q(grp_q), .nm_q(nm_q), .tr_q(tr_q), .en_q(en_q), .busy_q(busy));

  wep_lookup #(.LO_W(LO_W), .GRP_W(GRP_W), .NM_W(NM_W), .TR_W(TR_W), .EN_W(EN_W))
  u_look (.clk(clk), .rst(rst), .q_valid(q_valid), .lo_sel(q_lo), .grp_sel(q_grp), .nm_sel(q_nm),
          .tr_sel(q_tr), .en_sel(q_en), .covered(q_cov), .lo_q(lo_q), .grp_q(grp_q), .nm_q(nm_q),
          .tr_q(tr_q), .en_q(en_q), .hit_valid(hit_valid), .hit(hit));

  wep_erase_mon #(.BANK_W(BANK_W), .MAIN_SECTORS(MAIN_SECTORS), .LO_W(LO_W), .GRP_W(GRP_W), .GRP_SH(GRP_SH))
  u_emon (.clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_bank(cmd_bank), .busy(busy),
          .lo_q(lo_q), .grp_q(grp_q), .erase_done(erase_done));

  AST_BAD_REGION: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !$onehot(q_region)) |=> (hit_valid && hit)); // R6
  AST_ANSWER_NEXT: assert property (@(posedge clk) disable iff (rst)
    q_valid |=> hit_valid); // R7
  AST_NO_STRAY_ANSWER: assert property (@(posedge clk) disable iff (rst)
    !q_valid |=> (!hit_valid && !hit)); // R7
endmodule

// File: tb/sim_wep_guard.sv
`timescale 1ns/1ps
module sim_wep_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        cmd_start = 1'b0, cmd_done = 1'b0;
  logic [0:0]  cmd_bank = '0;
  logic        mark_valid = 1'b0;
  logic [0:0]  mark_bank = '0;
  logic [3:0]  mark_region = '0;
  logic [7:0]  mark_sector = '0;
  logic        q_valid = 1'b0;
  logic [0:0]  q_bank = '0;
  logic [3:0]  q_region = '0;
  logic [7:0]  q_sector = '0;
  logic        hit_valid, hit, busy, erase_done;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  wep_guard u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd_start(cmd_start), .cmd_bank(cmd_bank), .cmd_done(cmd_done), .mark_valid(mark_valid),
    .mark_bank(mark_bank), .mark_region(mark_region), .mark_sector(mark_sector), .q_valid(q_valid),
    .q_bank(q_bank), .q_region(q_region), .q_sector(q_sector), .hit_valid(hit_valid), .hit(hit),
    .busy(busy), .erase_done(erase_done));

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  // monitor: pops one expected answer per valid result
  always @(negedge clk) begin
    if (!rst && hit_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: unexpected answer got %0b expected none", hit);
      end else begin
        automatic logic e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(hit, e, t);
      end
    end
  end

  task automatic query(input logic [0:0] b, input logic [3:0] r, input logic [7:0] s,
                       input logic exp, input string tag);
    @(posedge clk); #1;
    q_valid = 1'b1; q_bank = b; q_region = r; q_sector = s;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    q_valid = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic mark(input logic [0:0] b, input logic [3:0] r, input logic [7:0] s);
    @(posedge clk); #1;
    mark_valid = 1'b1; mark_bank = b; mark_region = r; mark_sector = s;
    @(posedge clk); #1;
    mark_valid = 1'b0;
  endtask

  task automatic start(input logic [0:0] b);
    @(posedge clk); #1;
    cmd_start = 1'b1; cmd_bank = b;
    @(posedge clk); #1;
    cmd_start = 1'b0;
  endtask

  task automatic finish_cmd();
    @(posedge clk); #1;
    cmd_done = 1'b1;
    @(posedge clk); #1;
    cmd_done = 1'b0;
  endtask

  task automatic sample_next();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(busy, 1'b0, "R1 busy after reset");
    chk(hit_valid, 1'b0, "R1 hit_valid after reset");
    chk(erase_done, 1'b0, "R1 erase_done after reset");
    query(0, 4'h1, 5, 1, "R1 bank0 main");
    query(1, 4'h1, 0, 1, "R1 bank1 main");
    query(0, 4'h2, 0, 1, "R1 nonmain");
    query(0, 4'h4, 3, 1, "R1 trim");
    query(0, 4'h8, 2, 1, "R1 engr");

    wr(3'd0, 32'h0000_0001);
    query(0, 4'h1, 0, 1, "R2 low bit0 set");
    query(0, 4'h1, 1, 0, "R2 low bit1 clear");
    query(0, 4'h1, 31, 0, "R2 low bit31 clear");
    query(1, 4'h1, 1, 1, "R4 low reg ignored for bank1");

    wr(3'd1, 32'h0000_000F);
    query(0, 4'h1, 32, 0, "R3 group bits3:0 ignored bank0");
    query(0, 4'h1, 0, 1, "R3 low still governs bank0");
    query(1, 4'h1, 0, 1, "R4 bank1 sector0 group bit0");
    query(1, 4'h1, 31, 1, "R4 bank1 sector31 group bit3");
    query(1, 4'h1, 32, 0, "R4 bank1 sector32 group bit4");
    wr(3'd1, 32'h0000_0010);
    query(0, 4'h1, 39, 1, "R3 bank0 sector39 bit4");
    query(0, 4'h1, 40, 0, "R3 bank0 sector40 bit5");
    query(1, 4'h1, 0, 0, "R4 bank1 sector0 bit0 clear");
    query(1, 4'h1, 39, 1, "R4 bank1 sector39 bit4");

    query(1, 4'h1, 230, 1, "R5 main beyond group coverage");
    wr(3'd2, 32'h0);
    query(0, 4'h2, 0, 0, "R5 nonmain bit0 clear");
    query(0, 4'h2, 4, 1, "R5 nonmain beyond width");
    wr(3'd3, 32'h5);
    query(0, 4'h4, 1, 0, "R5 trim bit1");
    query(0, 4'h4, 2, 1, "R5 trim bit2");
    wr(3'd4, 32'h0);
    query(1, 4'h8, 3, 0, "R5 engr bit3");

    query(0, 4'h3, 1, 1, "R6 region 3");
    query(0, 4'h0, 1, 1, "R6 region 0");

    wr(3'd7, 32'h0);
    query(0, 4'h1, 0, 1, "R8 bad select leaves low");
    query(0, 4'h4, 2, 1, "R8 bad select leaves trim");

    start(0);
    @(negedge clk);
    chk(busy, 1'b1, "R9 busy after start");
    wr(3'd0, 32'h0);
    query(0, 4'h1, 0, 1, "R9 locked write ignored");
    wr(3'd2, 32'hF);
    query(0, 4'h2, 0, 0, "R9 locked region write ignored");

    mark(0, 4'h1, 1);
    query(0, 4'h1, 1, 1, "R11 mark low bit");
    mark(0, 4'h2, 0);
    query(0, 4'h2, 0, 1, "R11 mark nonmain bit");
    mark(1, 4'h1, 40);
    query(1, 4'h1, 44, 1, "R11 mark group bit5 bank1");
    query(0, 4'h1, 45, 1, "R11 group bit5 shared bank0");

    sample_next();
    chk(erase_done, 1'b0, "R12 not done early");
    for (int s = 2; s < 32; s++) mark(0, 4'h1, 8'(s));
    mark(0, 4'h1, 48);
    sample_next();
    chk(erase_done, 1'b0, "R12 one group left");
    mark(0, 4'h1, 56);
    sample_next();
    chk(erase_done, 1'b1, "R12 bank0 all masked");

    finish_cmd();
    @(negedge clk);
    chk(busy, 1'b0, "R10 busy cleared");
    query(1, 4'h1, 0, 1, "R10 group restored");
    query(1, 4'h8, 3, 1, "R10 engr restored");
    sample_next();
    chk(erase_done, 1'b0, "R12 idle after done");
    wr(3'd0, 32'h0);
    query(0, 4'h1, 3, 0, "R10 lock released");

    wr(3'd1, 32'h0000_007F);
    start(1);
    sample_next();
    chk(erase_done, 1'b0, "R12 bank1 bit7 open, low reg ignored");
    mark(1, 4'h1, 60);
    sample_next();
    chk(erase_done, 1'b1, "R12 bank1 all masked");
    finish_cmd();

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R7: got %0d pending answers expected 0", exp_q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule